// File: doc/BRIEF.md
# Single-Operand Register-File Datapath

This block carries out the single-operand operations of a small 8-bit core that act on its data register file. It holds the register file, the working register (W) and the zero flag (Z). On each valid operation it reads the addressed file entry and forms a result. The result is written either into W or back into the file entry, as the operation and its destination bit select. Z is then updated by the rule that belongs to that operation.

A bit-test operation does not change any state. It reports the selected bit of the addressed entry, so that the sequencer can decide whether to skip the next instruction. A clear-watchdog operation changes no datapath state. It produces single-cycle strobes that the surrounding logic uses:
- one strobe restarts the watchdog count;
- one strobe restarts the prescaler, and fires only when the prescaler is assigned to the watchdog;
- one strobe sets the timeout and power-down status flags.

The sequencer drives one operation per cycle with a valid bit. Every write lands at the clock edge that ends that cycle.

Top module: `rf_operate`

## Requirements
- R1: After reset, W reads 0, Z reads 0 and every file entry reads 0 through `opnd_o`.
- R2: Clear-file (op code 1) writes 0 to the addressed entry and sets Z to 1. W is unchanged.
- R3: Clear-W (op code 2) writes 0 to W and sets Z to 1. No file entry changes.
- R4: Complement with `dst_i`=0 (op code 3) loads W with the bitwise inverse of the addressed entry. The entry is unchanged. Z becomes 1 exactly when the result is 0, and 0 otherwise.
- R5: Complement with `dst_i`=1 (op code 3) replaces the addressed entry with its bitwise inverse. W is unchanged. Z follows the same rule as in R4.
- R6: Bit-test (op code 4) drives `bit_set_o` with bit `bsel_i` of the addressed entry in the same cycle. W, Z and the file stay unchanged.
- R7: Clear-watchdog (op code 5) raises `wdt_clr_o` and `flags_set_o` for that cycle. It raises `presc_clr_o` only when `presc_wdt_i` is 1. W, Z and the file stay unchanged.
- R8: When `op_valid_i` is 0, or the op code is 0 (no-op), all strobes and `bit_set_o` are 0 and no state changes.
- R9: `opnd_o` shows the entry addressed by `addr_i` in the same cycle. A write becomes visible after the clock edge that ends the operation's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid_i | input | 1 | An operation is present this cycle |
| op_i | input | 3 | Op code: 0 no-op, 1 clear-file, 2 clear-W, 3 complement, 4 bit-test, 5 clear-watchdog |
| addr_i | input | 5 | File entry address, 0 to 31 |
| bsel_i | input | 3 | Bit index for bit-test, 0 to 7 |
| dst_i | input | 1 | Complement destination: 0 to W, 1 back to the file |
| presc_wdt_i | input | 1 | 1 when the prescaler is assigned to the watchdog |
| opnd_o | output | 8 | Current contents of the addressed entry |
| w_o | output | 8 | Working register |
| z_o | output | 1 | Zero flag |
| bit_set_o | output | 1 | Tested bit, valid during a bit-test |
| wdt_clr_o | output | 1 | Strobe that restarts the watchdog count |
| presc_clr_o | output | 1 | Strobe that restarts the prescaler |
| flags_set_o | output | 1 | Strobe that sets the timeout and power-down flags |

## Verification
On every cycle, the assertions check the following:
- the Z and W outcomes of clear-file, clear-W and complement-to-W;
- that bit-test and an idle cycle leave W and Z untouched;
- that the prescaler strobe is only seen together with the watchdog strobe.

Only the bench scenarios can show the rest:
- that file entries keep or change their contents across sweeps of all 32 addresses and all 8 bit positions;
- that the zero rule of complement gives both outcomes;
- that no file entry is disturbed by the operations that must not write it.

// File: rtl/rf_operate_pkg.sv
package rf_operate_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_CLRF = 3'd1,
    OP_CLRW = 3'd2,
    OP_COMF = 3'd3,
    OP_BTST = 3'd4,
    OP_CWDT = 3'd5
  } op_e;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/rf_file.sv
module rf_file #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n_s,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we_i && (addr_i == AW'(g));

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        ent_q[g] <= '0;
      end else if (ent_en) begin
        ent_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = ent_q[addr_i];
endmodule

// File: rtl/rf_exec.sv
module rf_exec
  import rf_operate_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [BW-1:0] bsel_i,
  input  logic          dst_i,
  input  logic          presc_wdt_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] res_o,
  output logic          file_we_o,
  output logic          w_we_o,
  output logic          z_we_o,
  output logic          z_val_o,
  output logic          bit_o,
  output logic          wdt_clr_o,
  output logic          presc_clr_o,
  output logic          flags_set_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    res_o       = '0;
    file_we_o   = 1'b0;
    w_we_o      = 1'b0;
    z_we_o      = 1'b0;
    bit_o       = 1'b0;
    wdt_clr_o   = 1'b0;
    presc_clr_o = 1'b0;
    flags_set_o = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_CLRF: begin
          file_we_o = 1'b1;
          z_we_o    = 1'b1;
        end
        OP_CLRW: begin
          w_we_o = 1'b1;
          z_we_o = 1'b1;
        end
        OP_COMF: begin
          res_o     = ~opnd_i;
          file_we_o = dst_i;
          w_we_o    = !dst_i;
          z_we_o    = 1'b1;
        end
        OP_BTST: bit_o = opnd_i[bsel_i];
        OP_CWDT: begin
          wdt_clr_o   = 1'b1;
          flags_set_o = 1'b1;
          presc_clr_o = presc_wdt_i;
        end
        default: ;
      endcase
    end
  end

  assign z_val_o = (res_o == '0);
endmodule

// File: rtl/rf_operate.sv
module rf_operate
  import rf_operate_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 5,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bsel_i,
  input  logic          dst_i,
  input  logic          presc_wdt_i,
  output logic [DW-1:0] opnd_o,
  output logic [DW-1:0] w_o,
  output logic          z_o,
  output logic          bit_set_o,
  output logic          wdt_clr_o,
  output logic          presc_clr_o,
  output logic          flags_set_o
);
  logic          rst_n_s;
  logic [DW-1:0] res;
  logic          file_we;
  logic          w_we;
  logic          z_we;
  logic          z_val;
  logic [DW-1:0] w_q;
  logic [DW-1:0] w_d;
  logic          z_q;
  logic          z_d;

  rf_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  rf_file #(.DW(DW), .AW(AW)) u_file (
    .clk     (clk),
    .rst_n_s (rst_n_s),
    .we_i    (file_we),
    .addr_i  (addr_i),
    .wdata_i (res),
    .rdata_o (opnd_o)
  );

  rf_exec #(.DW(DW)) u_exec (
    .valid_i     (op_valid_i),
    .op_i        (op_i),
    .bsel_i      (bsel_i),
    .dst_i       (dst_i),
    .presc_wdt_i (presc_wdt_i),
    .opnd_i      (opnd_o),
    .res_o       (res),
    .file_we_o   (file_we),
    .w_we_o      (w_we),
    .z_we_o      (z_we),
    .z_val_o     (z_val),
    .bit_o       (bit_set_o),
    .wdt_clr_o   (wdt_clr_o),
    .presc_clr_o (presc_clr_o),
    .flags_set_o (flags_set_o)
  );

  always_comb begin
    w_d = w_q;
    z_d = z_q;
    if (w_we) w_d = res;
    if (z_we) z_d = z_val;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      w_q <= '0;
      z_q <= 1'b0;
    end else begin
      w_q <= w_d;
      z_q <= z_d;
    end
  end

  assign w_o = w_q;
  assign z_o = z_q;

  a_r2_clrf_sets_z: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid_i && op_i == OP_CLRF) |=> (z_o == 1'b1));

  a_r2_clrf_keeps_w: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid_i && op_i == OP_CLRF) |=> $stable(w_o));

  a_r3_clrw_result: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid_i && op_i == OP_CLRW) |=> (w_o == '0 && z_o == 1'b1));

  a_r4_comf_to_w: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid_i && op_i == OP_COMF && !dst_i) |=>
      (w_o == ~$past(opnd_o) && z_o == ($past(opnd_o) == '1)));

  a_r6_btst_keeps_state: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid_i && op_i == OP_BTST) |=> ($stable(z_o) && $stable(w_o)));

  a_r7_presc_needs_wdt: assert property (@(posedge clk) disable iff (!rst_n_s)
    presc_clr_o |-> (wdt_clr_o && flags_set_o && presc_wdt_i));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    !op_valid_i |-> !(bit_set_o || wdt_clr_o || presc_clr_o || flags_set_o));

  a_r8_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n_s)
    !op_valid_i |=> ($stable(w_o) && $stable(z_o)));
endmodule

// File: tb/rf_operate_tb_top.sv
module rf_operate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid_i;
  logic [2:0] op_i;
  logic [4:0] addr_i;
  logic [2:0] bsel_i;
  logic       dst_i;
  logic       presc_wdt_i;
  logic [7:0] opnd_o;
  logic [7:0] w_o;
  logic       z_o;
  logic       bit_set_o;
  logic       wdt_clr_o;
  logic       presc_clr_o;
  logic       flags_set_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] m_file [32];
  logic [7:0] m_w;
  logic       m_z;

  always #(CLK_PERIOD/2) clk = ~clk;

  rf_operate dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
    .addr_i(addr_i), .bsel_i(bsel_i), .dst_i(dst_i), .presc_wdt_i(presc_wdt_i),
    .opnd_o(opnd_o), .w_o(w_o), .z_o(z_o), .bit_set_o(bit_set_o),
    .wdt_clr_o(wdt_clr_o), .presc_clr_o(presc_clr_o), .flags_set_o(flags_set_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk(req, w_o, m_w);
    chk(req, {7'd0, z_o}, {7'd0, m_z});
    for (int a = 0; a < 32; a++) begin
      addr_i = 5'(a);
      #1;
      chk(req, opnd_o, m_file[a]);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [4:0] a, logic [2:0] b, logic d, logic p);
    @(negedge clk);
    op_valid_i  = 1'b1;
    op_i        = op;
    addr_i      = a;
    bsel_i      = b;
    dst_i       = d;
    presc_wdt_i = p;
    #1;
  endtask

  task automatic finish_op();
    @(negedge clk);
    op_valid_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_valid_i = 1'b0; op_i = '0; addr_i = '0; bsel_i = '0; dst_i = 1'b0; presc_wdt_i = 1'b0;
    for (int a = 0; a < 32; a++) m_file[a] = 8'h00;
    m_w = 8'h00;
    m_z = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_state("R1 reset");

    // R3 clear W
    issue(3'd2, 5'd7, 3'd0, 1'b0, 1'b0);
    chk("R9 opnd comb", opnd_o, m_file[7]);
    finish_op();
    m_w = 8'h00; m_z = 1'b1;
    chk_state("R3 clear-W");

    // R5 complement back to the file, every third address
    for (int a = 0; a < 32; a += 3) begin
      issue(3'd3, 5'(a), 3'd0, 1'b1, 1'b0);
      chk("R9 pre-edge value", opnd_o, m_file[a]);
      finish_op();
      m_file[a] = ~m_file[a];
      m_z = (m_file[a] == 8'h00);
      addr_i = 5'(a);
      #1;
      chk("R5 file written", opnd_o, m_file[a]);
      chk("R5 z", {7'd0, z_o}, {7'd0, m_z});
      chk("R5 w kept", w_o, m_w);
    end
    chk_state("R5 sweep");

    // R4 complement into W, all addresses
    for (int a = 0; a < 32; a++) begin
      issue(3'd3, 5'(a), 3'd0, 1'b0, 1'b0);
      finish_op();
      m_w = ~m_file[a];
      m_z = (m_w == 8'h00);
      chk("R4 w", w_o, m_w);
      chk("R4 z", {7'd0, z_o}, {7'd0, m_z});
      addr_i = 5'(a);
      #1;
      chk("R4 file kept", opnd_o, m_file[a]);
    end

    // R6 bit test, all addresses and bits
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 8; b++) begin
        issue(3'd4, 5'(a), 3'(b), 1'b1, 1'b0);
        chk("R6 bit", {7'd0, bit_set_o}, {7'd0, m_file[a][b]});
        chk("R6 no wdt strobe", {7'd0, wdt_clr_o}, 8'd0);
        finish_op();
      end
    end
    chk_state("R6 state kept");

    // R2 clear file on even addresses
    for (int a = 0; a < 32; a += 2) begin
      issue(3'd2, 5'(a), 3'd0, 1'b0, 1'b0);
      finish_op();
      m_w = 8'h00; m_z = 1'b1;
      issue(3'd3, 5'(a), 3'd0, 1'b1, 1'b0);
      finish_op();
      m_file[a] = ~m_file[a]; m_z = (m_file[a] == 8'h00);
      issue(3'd1, 5'(a), 3'd0, 1'b1, 1'b0);
      finish_op();
      m_file[a] = 8'h00; m_z = 1'b1;
      addr_i = 5'(a);
      #1;
      chk("R2 file cleared", opnd_o, 8'h00);
      chk("R2 z", {7'd0, z_o}, 8'd1);
      chk("R2 w kept", w_o, m_w);
    end
    chk_state("R2 sweep");

    // put a nonzero value in W and Z=0
    issue(3'd3, 5'd1, 3'd0, 1'b0, 1'b0);
    finish_op();
    m_w = ~m_file[1]; m_z = (m_w == 8'h00);

    // R7 clear watchdog, both prescaler assignments
    for (int p = 0; p < 2; p++) begin
      issue(3'd5, 5'd3, 3'd0, 1'b1, 1'(p));
      chk("R7 wdt strobe", {7'd0, wdt_clr_o}, 8'd1);
      chk("R7 flags strobe", {7'd0, flags_set_o}, 8'd1);
      chk("R7 presc strobe", {7'd0, presc_clr_o}, 8'(p));
      finish_op();
      chk("R7 strobes drop", {5'd0, wdt_clr_o, flags_set_o, presc_clr_o}, 8'd0);
    end
    chk_state("R7 state kept");

    // R8 idle cycles with every op code present, and valid no-op
    for (int o = 0; o < 8; o++) begin
      @(negedge clk);
      op_valid_i = 1'b0; op_i = 3'(o); addr_i = 5'd0; bsel_i = 3'd0;
      dst_i = 1'(o & 1); presc_wdt_i = 1'b1;
      #1;
      chk("R8 idle strobes", {4'd0, bit_set_o, wdt_clr_o, presc_clr_o, flags_set_o}, 8'd0);
    end
    issue(3'd0, 5'd0, 3'd0, 1'b1, 1'b1);
    chk("R8 nop strobes", {4'd0, bit_set_o, wdt_clr_o, presc_clr_o, flags_set_o}, 8'd0);
    finish_op();
    chk_state("R8 state kept");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule